// File: doc/BRIEF.md
# Command and Parameter Register Bank

This block is the software-facing control bank of a connection-oriented transport engine. It presents sixteen 32-bit locations behind a single-port-RAM style port: one shared 4-bit address, a write enable that qualifies write data in the same cycle, and read data that is registered and appears one clock after the address. The bank holds the connection parameters (local hardware address, both network addresses, both port numbers and the client/server start-up mode), a hold bit that keeps the downstream engine parked, a packet-length setting, a pending total-transmit length and a write-only length extension.

Clearing the hold bit copies the held parameters onto the engine-facing outputs and fires a one-cycle initialisation pulse. Later parameter writes only reach the engine on the next release of the hold bit. Writing a legal command code, while the bank is not busy, raises a one-cycle start strobe with the command code. A send command also copies the pending length into a live countdown. The engine lowers the countdown one 32-byte beat at a time, and software may lengthen it while the command runs. The command location reads back busy and current-operation status instead of the value written, and the length location reads back the remaining byte count.

Top module: `cmd_param_regbank`

## Requirements
- R1: A write takes effect at the clock edge where `reg_we` is high, with address and data taken in that same cycle. `reg_rdata` shows the content of the location addressed in the previous cycle, as it stood before any write in that cycle.
- R2: The hold bit (address 0, bit 0) resets to 1. Its 1-to-0 transition copies the held hardware address, network addresses, ports and mode onto the `par_*` outputs and raises `init_start` for exactly one cycle. Parameter writes made while the hold bit is 0 leave the `par_*` outputs unchanged until the next 1-to-0 transition.
- R3: Writing address 1 with code 00 (send), 10 (open) or 11 (close) while idle raises `eng_start` for one cycle, one clock after the write, with `eng_cmd` equal to the code. Code 01 is ignored: no strobe, no busy, and `eng_cmd` keeps its previous value.
- R4: Reading address 1 returns busy in bit 0 and `eng_op` in bits [3:1], with zero in the upper bits. Busy is 1 in the cycle after an accepted command write. After that it follows `eng_busy`.
- R5: A command write made while busy reads 1 is ignored.
- R6: A write to address 8 stores the value with bits [4:0] cleared as the pending length. An accepted send command copies the pending length into the remaining count. Open and close commands leave the remaining count alone. Reading address 8 returns the remaining count.
- R7: Each cycle with `tx_beat` high lowers the remaining count by 32. The count stops at 0.
- R8: A write to address 13 while busy adds the value, with bits [4:0] cleared, to the remaining count. The sum saturates at 0xFFFFFFE0. The same write while idle has no effect.
- R9: The packet length (address 10) resets to 1440. A write keeps bits [15:0], clears bits [4:0] and then clamps the result to the range 32 to 16000. The result is shown on `par_pkt_len` without waiting for the hold bit.
- R10: Addresses 3, 6 and 7 store only the low 16 bits of a write and read back zero in bits [31:16]. Address 14 stores bit 0 only (0 = client start-up, 1 = server start-up).
- R11: Addresses 9, 11, 12 and 13 read as zero. Address 15 reads the `VERSION` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Shared read/write address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable |
| reg_rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle command start strobe |
| eng_cmd | output | 2 | Code of the last accepted command |
| eng_busy | input | 1 | Engine busy indication |
| eng_op | input | 3 | Engine current-operation code |
| tx_beat | input | 1 | One 32-byte beat sent this cycle |
| rem_len | output | 32 | Remaining transmit byte count |
| core_hold | output | 1 | Hold bit |
| init_start | output | 1 | One-cycle initialisation pulse |
| par_mac | output | 48 | Loaded local hardware address |
| par_dst_ip | output | 32 | Loaded remote network address |
| par_src_ip | output | 32 | Loaded local network address |
| par_dst_port | output | 16 | Loaded remote port |
| par_src_port | output | 16 | Loaded local port |
| par_server | output | 1 | Loaded start-up mode |
| par_pkt_len | output | 16 | Current packet length |

## Verification
The bench builds the bank with its default parameters: 32-byte beats, packet limits of 32 and 16000, and a default packet length of 1440. With these values, a single packet-length write reaches each clamp edge and the bit-masking case. A pending length of 0xFFFFFFFF lets one extension write reach the saturation ceiling within a few cycles. A small pending length drains to zero in nine beats, so the floor of the countdown is reached in a short run. A behavioural model, built from integer arithmetic, tracks every output on every clock.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned RA_HOLD  = 0;
  localparam int unsigned RA_CMD   = 1;
  localparam int unsigned RA_MACL  = 2;
  localparam int unsigned RA_MACH  = 3;
  localparam int unsigned RA_DIP   = 4;
  localparam int unsigned RA_SIP   = 5;
  localparam int unsigned RA_DPORT = 6;
  localparam int unsigned RA_SPORT = 7;
  localparam int unsigned RA_TLEN  = 8;
  localparam int unsigned RA_PLEN  = 10;
  localparam int unsigned RA_EXT   = 13;
  localparam int unsigned RA_MODE  = 14;
  localparam int unsigned RA_VER   = 15;

  typedef enum logic [1:0] {
    CMD_SEND  = 2'b00,
    CMD_UNDEF = 2'b01,
    CMD_OPEN  = 2'b10,
    CMD_CLOSE = 2'b11
  } cmd_e;

  // clear the low 'ab' bits (beat alignment)
  function automatic logic [REG_W-1:0] align_down(input logic [REG_W-1:0] v,
                                                   input int unsigned ab);
    logic [REG_W-1:0] mask;
    mask = {REG_W{1'b1}} << ab;
    return v & mask;
  endfunction

  // add with a ceiling
  function automatic logic [REG_W-1:0] sat_add(input logic [REG_W-1:0] a,
                                                input logic [REG_W-1:0] b,
                                                input logic [REG_W-1:0] lim);
    logic [REG_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, lim}) ? lim : s[REG_W-1:0];
  endfunction

  // subtract with a floor of zero
  function automatic logic [REG_W-1:0] floor_sub(input logic [REG_W-1:0] a,
                                                  input logic [REG_W-1:0] step);
    return (a >= step) ? (a - step) : '0;
  endfunction

  // keep low 'fw' bits, align, clamp to [lo, hi]
  function automatic logic [REG_W-1:0] fix_pkt(input logic [REG_W-1:0] v,
                                                input int unsigned fw,
                                                input int unsigned ab,
                                                input logic [REG_W-1:0] lo,
                                                input logic [REG_W-1:0] hi);
    logic [REG_W-1:0] t;
    t = v & ~({REG_W{1'b1}} << fw);
    t = align_down(t, ab);
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    return t;
  endfunction
endpackage

// File: rtl/cpr_addr_dec.sv
module cpr_addr_dec #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = we && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/cpr_len_ctr.sv
module cpr_len_ctr
  import cpr_pkg::*;
#(
  parameter int unsigned BEAT_BYTES = 32,
  localparam int unsigned ALIGN = $clog2(BEAT_BYTES),
  localparam logic [REG_W-1:0] LEN_MAX = {REG_W{1'b1}} << ALIGN,
  localparam logic [REG_W-1:0] BEAT = REG_W'(BEAT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tlen_we,
  input  logic             ext_apply,
  input  logic [REG_W-1:0] wdata,
  input  logic             load,
  input  logic             beat,
  output logic [REG_W-1:0] rem
);
  logic [REG_W-1:0] pend;
  logic [REG_W-1:0] grown;
  logic [REG_W-1:0] rem_nxt;

  always_comb begin
    grown   = sat_add(rem, ext_apply ? align_down(wdata, ALIGN) : '0, LEN_MAX);
    rem_nxt = floor_sub(grown, beat ? BEAT : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      rem  <= '0;
    end else begin
      if (tlen_we) pend <= align_down(wdata, ALIGN);
      if (load) rem <= pend;
      else      rem <= rem_nxt;
    end
  end
endmodule

// File: rtl/cpr_param_bank.sv
module cpr_param_bank
  import cpr_pkg::*;
#(
  parameter int unsigned PORT_W  = 16,
  parameter int unsigned NREG    = 16,
  parameter int unsigned ALIGN   = 5,
  parameter int unsigned PKT_DEF = 1440,
  parameter int unsigned PKT_MIN = 32,
  parameter int unsigned PKT_MAX = 16000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_hit,
  input  logic [REG_W-1:0]  wdata,
  output logic              hold,
  output logic              init_pulse,
  output logic [REG_W-1:0]  sh_mac_lo,
  output logic [PORT_W-1:0] sh_mac_hi,
  output logic [REG_W-1:0]  sh_dip,
  output logic [REG_W-1:0]  sh_sip,
  output logic [PORT_W-1:0] sh_dport,
  output logic [PORT_W-1:0] sh_sport,
  output logic              sh_srv,
  output logic [PORT_W-1:0] pkt_len,
  output logic [REG_W+PORT_W-1:0] ld_mac,
  output logic [REG_W-1:0]  ld_dip,
  output logic [REG_W-1:0]  ld_sip,
  output logic [PORT_W-1:0] ld_dport,
  output logic [PORT_W-1:0] ld_sport,
  output logic              ld_srv
);
  logic hold_fall;
  assign hold_fall = wr_hit[RA_HOLD] && hold && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= 1'b1;
      init_pulse <= 1'b0;
      sh_mac_lo  <= '0;
      sh_mac_hi  <= '0;
      sh_dip     <= '0;
      sh_sip     <= '0;
      sh_dport   <= '0;
      sh_sport   <= '0;
      sh_srv     <= 1'b0;
      pkt_len    <= PORT_W'(PKT_DEF);
    end else begin
      init_pulse <= hold_fall;
      if (wr_hit[RA_HOLD])  hold      <= wdata[0];
      if (wr_hit[RA_MACL])  sh_mac_lo <= wdata;
      if (wr_hit[RA_MACH])  sh_mac_hi <= wdata[PORT_W-1:0];
      if (wr_hit[RA_DIP])   sh_dip    <= wdata;
      if (wr_hit[RA_SIP])   sh_sip    <= wdata;
      if (wr_hit[RA_DPORT]) sh_dport  <= wdata[PORT_W-1:0];
      if (wr_hit[RA_SPORT]) sh_sport  <= wdata[PORT_W-1:0];
      if (wr_hit[RA_MODE])  sh_srv    <= wdata[0];
      if (wr_hit[RA_PLEN])
        pkt_len <= PORT_W'(fix_pkt(wdata, PORT_W, ALIGN, REG_W'(PKT_MIN), REG_W'(PKT_MAX)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_mac   <= '0;
      ld_dip   <= '0;
      ld_sip   <= '0;
      ld_dport <= '0;
      ld_sport <= '0;
      ld_srv   <= 1'b0;
    end else if (hold_fall) begin
      ld_mac   <= {sh_mac_hi, sh_mac_lo};
      ld_dip   <= sh_dip;
      ld_sip   <= sh_sip;
      ld_dport <= sh_dport;
      ld_sport <= sh_sport;
      ld_srv   <= sh_srv;
    end
  end
endmodule

// File: rtl/cmd_param_regbank.sv
module cmd_param_regbank
  import cpr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned PORT_W     = 16,
  parameter int unsigned OP_W       = 3,
  parameter int unsigned BEAT_BYTES = 32,
  parameter int unsigned PKT_DEF    = 1440,
  parameter int unsigned PKT_MIN    = 32,
  parameter int unsigned PKT_MAX    = 16000,
  parameter logic [31:0] VERSION    = 32'h0103_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              eng_start,
  output logic [1:0]        eng_cmd,
  input  logic              eng_busy,
  input  logic [OP_W-1:0]   eng_op,
  input  logic              tx_beat,
  output logic [REG_W-1:0]  rem_len,
  output logic              core_hold,
  output logic              init_start,
  output logic [REG_W+PORT_W-1:0] par_mac,
  output logic [REG_W-1:0]  par_dst_ip,
  output logic [REG_W-1:0]  par_src_ip,
  output logic [PORT_W-1:0] par_dst_port,
  output logic [PORT_W-1:0] par_src_port,
  output logic              par_server,
  output logic [PORT_W-1:0] par_pkt_len
);
  localparam int unsigned NREG  = 1 << ADDR_W;
  localparam int unsigned ALIGN = $clog2(BEAT_BYTES);
  localparam int unsigned PADW  = REG_W - PORT_W;
  localparam int unsigned STW   = REG_W - OP_W - 1;

  logic [NREG-1:0]   wr_hit;
  logic              busy_q;
  logic              cmd_accept;
  logic              send_load;
  logic              ext_apply;
  logic [REG_W-1:0]  sh_mac_lo, sh_dip, sh_sip;
  logic [PORT_W-1:0] sh_mac_hi, sh_dport, sh_sport;
  logic              sh_srv;
  logic [REG_W-1:0]  rd_nxt;

  cpr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .we(reg_we), .addr(reg_addr), .wr_hit(wr_hit)
  );

  // command acceptance: idle and a defined code
  assign cmd_accept = wr_hit[RA_CMD] && !busy_q && (reg_wdata[1:0] != CMD_UNDEF);
  assign send_load  = cmd_accept && (reg_wdata[1:0] == CMD_SEND);
  assign ext_apply  = wr_hit[RA_EXT] && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      eng_start <= 1'b0;
      eng_cmd   <= CMD_SEND;
    end else begin
      busy_q    <= cmd_accept ? 1'b1 : eng_busy;
      eng_start <= cmd_accept;
      if (cmd_accept) eng_cmd <= reg_wdata[1:0];
    end
  end

  cpr_len_ctr #(.BEAT_BYTES(BEAT_BYTES)) u_len (
    .clk(clk), .rst_n(rst_n),
    .tlen_we(wr_hit[RA_TLEN]), .ext_apply(ext_apply), .wdata(reg_wdata),
    .load(send_load), .beat(tx_beat), .rem(rem_len)
  );

  cpr_param_bank #(
    .PORT_W(PORT_W), .NREG(NREG), .ALIGN(ALIGN),
    .PKT_DEF(PKT_DEF), .PKT_MIN(PKT_MIN), .PKT_MAX(PKT_MAX)
  ) u_par (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(reg_wdata),
    .hold(core_hold), .init_pulse(init_start),
    .sh_mac_lo(sh_mac_lo), .sh_mac_hi(sh_mac_hi), .sh_dip(sh_dip), .sh_sip(sh_sip),
    .sh_dport(sh_dport), .sh_sport(sh_sport), .sh_srv(sh_srv), .pkt_len(par_pkt_len),
    .ld_mac(par_mac), .ld_dip(par_dst_ip), .ld_sip(par_src_ip),
    .ld_dport(par_dst_port), .ld_sport(par_src_port), .ld_srv(par_server)
  );

  always_comb begin
    rd_nxt = '0;
    case (int'(reg_addr))
      RA_HOLD:  rd_nxt = {{(REG_W-1){1'b0}}, core_hold};
      RA_CMD:   rd_nxt = {{STW{1'b0}}, eng_op, busy_q};
      RA_MACL:  rd_nxt = sh_mac_lo;
      RA_MACH:  rd_nxt = {{PADW{1'b0}}, sh_mac_hi};
      RA_DIP:   rd_nxt = sh_dip;
      RA_SIP:   rd_nxt = sh_sip;
      RA_DPORT: rd_nxt = {{PADW{1'b0}}, sh_dport};
      RA_SPORT: rd_nxt = {{PADW{1'b0}}, sh_sport};
      RA_TLEN:  rd_nxt = rem_len;
      RA_PLEN:  rd_nxt = {{PADW{1'b0}}, par_pkt_len};
      RA_MODE:  rd_nxt = {{(REG_W-1){1'b0}}, sh_srv};
      RA_VER:   rd_nxt = VERSION;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/cpr_chk.sv
module cpr_chk #(
  parameter int unsigned PKT_MIN = 32,
  parameter int unsigned PKT_MAX = 16000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic        cmd_accept,
  input logic        send_load,
  input logic        ext_apply,
  input logic        busy_q,
  input logic        eng_start,
  input logic        tx_beat,
  input logic [31:0] rem_len,
  input logic        core_hold,
  input logic        init_start,
  input logic [15:0] par_pkt_len
);
  p_hold_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> init_start);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_busy_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (busy_q && eng_start));

  p_cmd_ignored_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd1 && busy_q) |=> !eng_start);

  p_beat_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_beat && !send_load && !ext_apply && rem_len >= 32'd32)
      |=> rem_len == $past(rem_len) - 32'd32);

  p_no_growth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_load && !ext_apply) |=> rem_len <= $past(rem_len));

  p_pkt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(par_pkt_len) >= PKT_MIN) && (32'(par_pkt_len) <= PKT_MAX));
endmodule

bind cmd_param_regbank cpr_chk #(.PKT_MIN(PKT_MIN), .PKT_MAX(PKT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cmd_accept(cmd_accept), .send_load(send_load), .ext_apply(ext_apply),
  .busy_q(busy_q), .eng_start(eng_start), .tx_beat(tx_beat), .rem_len(rem_len),
  .core_hold(core_hold), .init_start(init_start), .par_pkt_len(par_pkt_len)
);

// File: tb/sim_cmd_param_regbank.sv
`timescale 1ns/1ps
module sim_cmd_param_regbank;
  localparam logic [31:0] VER = 32'h0103_0000;

  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rem_len, par_dst_ip, par_src_ip;
  logic reg_we = 0, eng_start, eng_busy = 0, tx_beat = 0, core_hold, init_start, par_server;
  logic [1:0] eng_cmd;
  logic [2:0] eng_op = 3'b101;
  logic [47:0] par_mac;
  logic [15:0] par_dst_port, par_src_port, par_pkt_len;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  cmd_param_regbank #(.VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .eng_start(eng_start), .eng_cmd(eng_cmd),
    .eng_busy(eng_busy), .eng_op(eng_op), .tx_beat(tx_beat), .rem_len(rem_len),
    .core_hold(core_hold), .init_start(init_start), .par_mac(par_mac),
    .par_dst_ip(par_dst_ip), .par_src_ip(par_src_ip), .par_dst_port(par_dst_port),
    .par_src_port(par_src_port), .par_server(par_server), .par_pkt_len(par_pkt_len)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_regs [16];
  longint m_rem, m_pend;
  bit m_busy, m_hold, m_init, m_start;
  logic [1:0] m_cmd;
  logic [31:0] m_rdata;
  logic [47:0] m_mac;
  logic [31:0] m_dip, m_sip;
  logic [15:0] m_dp, m_sp, m_pkt;
  bit m_srv;

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0:  return {31'd0, m_hold};
      1:  return {28'd0, eng_op, m_busy};
      8:  return m_rem[31:0];
      10: return {16'd0, m_pkt};
      15: return VER;
      2, 3, 4, 5, 6, 7, 14: return m_regs[a];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_regs[i]) m_regs[i] = 0;
      m_rem = 0; m_pend = 0; m_busy = 0; m_hold = 1; m_init = 0; m_start = 0;
      m_cmd = 0; m_rdata = 0; m_mac = 0; m_dip = 0; m_sip = 0; m_dp = 0; m_sp = 0;
      m_pkt = 16'd1440; m_srv = 0;
    end else begin
      automatic int a = int'(reg_addr);
      automatic bit wr = reg_we;
      automatic bit acc = wr && a == 1 && !m_busy && reg_wdata[1:0] != 2'b01;
      m_rdata = m_read(a);
      if (acc && reg_wdata[1:0] == 2'b00) m_rem = m_pend;
      else begin
        if (wr && a == 13 && m_busy) m_rem = m_rem + (reg_wdata & 32'hFFFF_FFE0);
        if (m_rem > 64'hFFFF_FFE0) m_rem = 64'hFFFF_FFE0;
        if (tx_beat) m_rem = (m_rem >= 32) ? m_rem - 32 : 0;
      end
      if (wr && a == 8) m_pend = reg_wdata & 32'hFFFF_FFE0;
      m_busy = acc ? 1'b1 : eng_busy;
      m_start = acc;
      if (acc) m_cmd = reg_wdata[1:0];
      m_init = wr && a == 0 && m_hold && !reg_wdata[0];
      if (m_init) begin
        m_mac = {m_regs[3][15:0], m_regs[2]}; m_dip = m_regs[4]; m_sip = m_regs[5];
        m_dp = m_regs[6][15:0]; m_sp = m_regs[7][15:0]; m_srv = m_regs[14][0];
      end
      if (wr && a == 0) m_hold = reg_wdata[0];
      if (wr && (a == 2 || a == 4 || a == 5)) m_regs[a] = reg_wdata;
      if (wr && (a == 3 || a == 6 || a == 7)) m_regs[a] = {16'd0, reg_wdata[15:0]};
      if (wr && a == 14) m_regs[a] = {31'd0, reg_wdata[0]};
      if (wr && a == 10) begin
        automatic int p = int'(reg_wdata[15:0]) & 32'hFFE0;
        if (p < 32) p = 32;
        if (p > 16000) p = 16000;
        m_pkt = 16'(p);
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R1 rdata", reg_rdata, m_rdata);
    chk("R3 start", eng_start, m_start);
    chk("R3 cmd", eng_cmd, m_cmd);
    chk("R6 rem", rem_len, m_rem[31:0]);
    chk("R2 hold", core_hold, m_hold);
    chk("R2 init", init_start, m_init);
    chk("R2 mac", par_mac, m_mac);
    chk("R2 ip", {par_dst_ip, par_src_ip}, {m_dip, m_sip});
    chk("R2 ports", {par_dst_port, par_src_port, par_server}, {m_dp, m_sp, m_srv});
    chk("R9 pkt", par_pkt_len, m_pkt);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_we = 0; reg_addr = 4'(a);
    @(negedge clk); chk(tag, reg_rdata, exp);
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_beat = 1;
    end
    @(negedge clk); tx_beat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 32'd1, "R2 hold default");
    rd(10, 32'd1440, "R9 pkt default");
    rd(1, 32'hA, "R4 status idle init-op");

    wr(2, 32'h1122_3344); wr(3, 32'hABCD_5566); wr(4, 32'hC0A8_0001);
    wr(5, 32'hC0A8_0002); wr(6, 32'hFFFF_1388); wr(7, 32'h0000_0050); wr(14, 32'h3);
    rd(3, 32'h5566, "R10 mac hi 16-bit");
    rd(6, 32'h1388, "R10 port 16-bit");
    rd(14, 32'h1, "R10 mode bit");
    chk("R2 params before release", par_mac, 48'h0);
    rd(4, 32'hC0A8_0001, "R1 read latency");

    wr(0, 32'h0);
    chk("R2 init pulse", init_start, 1'b1);
    chk("R2 mac loaded", par_mac, 48'h5566_1122_3344);
    chk("R2 server loaded", par_server, 1'b1);
    wr(2, 32'hDEAD_BEEF);
    chk("R2 mac unchanged", par_mac, 48'h5566_1122_3344);
    wr(0, 32'h1); wr(0, 32'h0);
    chk("R2 mac reloaded", par_mac, 48'h5566_DEAD_BEEF);

    eng_op = 3'b001;
    wr(8, 32'h0000_013F);
    rd(8, 32'h0, "R6 pending not live");
    wr(1, 32'h1);
    chk("R3 undefined ignored", eng_start, 1'b0);
    rd(1, 32'h2, "R3 undefined no busy");
    wr(1, 32'h0);
    chk("R3 send start", eng_start, 1'b1);
    chk("R3 send code", eng_cmd, 2'b00);
    chk("R6 loaded", rem_len, 32'h120);
    eng_busy = 1; eng_op = 3'b000;
    rd(1, 32'h1, "R4 busy readback");
    wr(1, 32'h2);
    chk("R5 ignored while busy", eng_start, 1'b0);
    chk("R5 code kept", eng_cmd, 2'b00);
    beats(2);
    rd(8, 32'hE0, "R7 two beats");
    wr(13, 32'h45);
    rd(8, 32'h120, "R8 extension");
    beats(10);
    rd(8, 32'h0, "R7 floor at zero");
    eng_busy = 0; eng_op = 3'b001;
    @(negedge clk);
    wr(13, 32'h100);
    rd(8, 32'h0, "R8 idle extension ignored");
    wr(1, 32'h2);
    chk("R3 open code", eng_cmd, 2'b10);
    chk("R6 open no load", rem_len, 32'h0);

    wr(8, 32'hFFFF_FFFF);
    wr(1, 32'h0);
    eng_busy = 1; eng_op = 3'b000;
    chk("R6 max load", rem_len, 32'hFFFF_FFE0);
    wr(13, 32'h100);
    rd(8, 32'hFFFF_FFE0, "R8 saturation");
    beats(1);
    rd(8, 32'hFFFF_FFC0, "R7 one beat");
    eng_busy = 0; eng_op = 3'b001;

    wr(10, 32'd5);       rd(10, 32'd32, "R9 clamp low");
    wr(10, 32'd20000);   rd(10, 32'd16000, "R9 clamp high");
    wr(10, 32'h12345);   rd(10, 32'h2340, "R9 mask");

    rd(9, 32'h0, "R11 addr9 zero");
    rd(11, 32'h0, "R11 addr11 zero");
    rd(12, 32'h0, "R11 addr12 zero");
    rd(13, 32'h0, "R11 ext reads zero");
    rd(15, VER, "R11 version");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule